// File: doc/BRIEF.md
# Context-Pointer Register Bank Unit

This unit serves general-purpose register accesses from a window of on-chip word RAM rather than from flip-flops. A context pointer register holds the byte base address of the active bank of sixteen 16-bit words. Each request names a register and an access width: a whole word, one of sixteen byte halves that overlay the first eight words, or one bit of any word. The unit adds the scaled register index to the pointer, drives a synchronous single-port RAM, and returns read results on a registered output.

Byte and bit writes are done as read-modify-write, so the rest of the word is kept. During a read or a read-modify-write the unit raises a busy flag, and it ignores any request made while that flag is high. Word writes finish in one RAM cycle and do not raise busy. The pointer can be loaded directly. A switch-context command loads a new pointer and also gives the old pointer, with a single-cycle strobe, to an external stack-push interface. Only the pointer selects the bank. No page register has any effect on the address.

Top module: `cpbank_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, cp_value is 0 and push_valid, req_busy, rd_valid and ram_en are all low.
- R2: An accepted request drives ram_en high in the next cycle. ram_addr is then (cp_value/2 + w) modulo the RAM word count. w is req_reg for word and bit accesses, and req_reg/2 for byte accesses.
- R3: A word read (req_kind 0) returns the whole RAM word on rd_data, with rd_valid high for one cycle, in the third cycle after the accepting clock edge.
- R4: A byte read (req_kind 1) uses req_reg bit 0 to pick the half: 1 selects bits 15:8 and 0 selects bits 7:0. The byte comes back zero-extended, with the same timing as R3.
- R5: A byte write replaces only the selected half with req_wdata[7:0]. The other half of the word is kept.
- R6: A bit access (req_kind 2) uses req_bit to pick a bit. A read returns it in rd_data[0] with all upper bits zero. A write sets that bit to req_wdata[0] and keeps the other 15 bits.
- R7: An accepted read or byte/bit write holds req_busy high for the next two cycles. Requests presented while req_busy is high are ignored.
- R8: A cp_load pulse sets cp_value to cp_wdata with bit 0 cleared, one cycle later. Requests accepted after that use the new base.
- R9: A switch-context pulse sets cp_value to scxt_cp with bit 0 cleared. In that same cycle, push_valid is high for one cycle and push_data holds the previous pointer. When both are pulsed together, the switch takes priority over cp_load.
- R10: A word write issues one RAM write of req_wdata in the next cycle, and req_busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 0 word, 1 byte, 2 bit |
| req_reg | input | 4 | Word register index, or byte register index |
| req_bit | input | 4 | Bit index for bit accesses |
| req_wdata | input | 16 | Write data |
| req_busy | output | 1 | Unit busy; requests are ignored |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 16 | Read result |
| cp_load | input | 1 | Direct pointer load |
| cp_wdata | input | 12 | Pointer value to load |
| scxt_valid | input | 1 | Switch-context command |
| scxt_cp | input | 12 | New pointer for the switch |
| cp_value | output | 12 | Current context pointer (byte address) |
| push_valid | output | 1 | Old pointer push strobe |
| push_data | output | 12 | Old pointer value |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 11 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, registered one cycle after ram_en |

## Verification
Counted from the clock edge that accepts a request, the RAM command appears one cycle later. Read data comes back on the third cycle, and a read-modify-write writes back on the third cycle. Busy covers cycles one and two. Pointer loads and the push strobe land one cycle after their pulse. The bench drives inputs on falling edges, counts rising edges from acceptance, and samples each result on the falling edge of the exact cycle it is due. Random accesses over several banks are compared against a shadow memory in the bench, and directed cases cover both byte halves, bit 15, pointer wrap, intrusion while busy, and a switch issued together with a load.

// File: rtl/cpbank_pkg.sv
package cpbank_pkg;
  typedef enum logic [1:0] {
    ACC_WORD = 2'd0,
    ACC_BYTE = 2'd1,
    ACC_BIT  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cpbank_ctx.sv
module cpbank_ctx #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              swap,
  input  logic [ADDR_W-1:0] swap_val,
  output logic [ADDR_W-1:0] cp_q,
  output logic              push_valid,
  output logic [ADDR_W-1:0] push_data
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_q       <= '0;
      push_valid <= 1'b0;
      push_data  <= '0;
    end else begin
      push_valid <= 1'b0;
      if (swap) begin
        cp_q       <= swap_val & ALIGN_MASK;
        push_valid <= 1'b1;
        push_data  <= cp_q;
      end else if (load) begin
        cp_q <= load_val & ALIGN_MASK;
      end
    end
  end

  AST_SWITCH_PUSHES_OLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(swap)) |-> (push_valid && push_data == $past(cp_q))); // R9

  AST_LOAD_TAKES_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load) && !$past(swap)) |->
      (cp_q == ($past(load_val) & ALIGN_MASK))); // R8
endmodule

// File: rtl/cpbank_addr.sv
module cpbank_addr
  import cpbank_pkg::*;
#(
  parameter int WADDR_W = 11,
  parameter int IDX_W   = 4
) (
  input  logic [WADDR_W-1:0] cp_word,
  input  acc_kind_e          kind,
  input  logic [IDX_W-1:0]   idx,
  output logic [WADDR_W-1:0] waddr
);
  logic [IDX_W-1:0] word_sel;

  always_comb begin
    if (kind == ACC_BYTE) word_sel = {1'b0, idx[IDX_W-1:1]};
    else                  word_sel = idx;
    waddr = cp_word + WADDR_W'(word_sel);
  end
endmodule

// File: rtl/cpbank_lane.sv
module cpbank_lane
  import cpbank_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF  = DATA_W / 2,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  acc_kind_e         kind,
  input  logic              sel_hi,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_out,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    rd_out = rdata;
    merged = wdata;
    case (kind)
      ACC_BYTE: begin
        if (sel_hi) begin
          rd_out = {{HALF{1'b0}}, rdata[DATA_W-1:HALF]};
          merged = {wdata[HALF-1:0], rdata[HALF-1:0]};
        end else begin
          rd_out = {{HALF{1'b0}}, rdata[HALF-1:0]};
          merged = {rdata[DATA_W-1:HALF], wdata[HALF-1:0]};
        end
      end
      ACC_BIT: begin
        rd_out          = '0;
        rd_out[0]       = rdata[bit_idx];
        merged          = rdata;
        merged[bit_idx] = wdata[0];
      end
      default: begin
        rd_out = rdata;
        merged = wdata;
      end
    endcase
  end
endmodule

// File: rtl/cpbank_unit.sv
module cpbank_unit
  import cpbank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int REG_CNT   = 16,
  localparam int WADDR_W  = ADDR_W - 1,
  localparam int IDX_W    = $clog2(REG_CNT),
  localparam int BIT_W    = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_kind,
  input  logic [IDX_W-1:0]   req_reg,
  input  logic [BIT_W-1:0]   req_bit,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_busy,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               cp_load,
  input  logic [ADDR_W-1:0]  cp_wdata,
  input  logic               scxt_valid,
  input  logic [ADDR_W-1:0]  scxt_cp,
  output logic [ADDR_W-1:0]  cp_value,
  output logic               push_valid,
  output logic [ADDR_W-1:0]  push_data,
  output logic               ram_en,
  output logic               ram_we,
  output logic [WADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata
);
  seq_state_e        state;
  acc_kind_e         in_kind;
  acc_kind_e         q_kind;
  logic              q_write;
  logic              q_hi;
  logic [BIT_W-1:0]  q_bit;
  logic [DATA_W-1:0] q_wdata;
  logic [WADDR_W-1:0] req_waddr;
  logic [DATA_W-1:0] lane_rd;
  logic [DATA_W-1:0] lane_merged;
  logic              accept;

  assign in_kind  = acc_kind_e'(req_kind);
  assign req_busy = (state != ST_IDLE);
  assign accept   = req_valid && (state == ST_IDLE);

  cpbank_ctx #(.ADDR_W(ADDR_W)) u_ctx (
    .clk       (clk),
    .rst       (rst),
    .load      (cp_load),
    .load_val  (cp_wdata),
    .swap      (scxt_valid),
    .swap_val  (scxt_cp),
    .cp_q      (cp_value),
    .push_valid(push_valid),
    .push_data (push_data)
  );

  cpbank_addr #(.WADDR_W(WADDR_W), .IDX_W(IDX_W)) u_addr (
    .cp_word(cp_value[ADDR_W-1:1]),
    .kind   (in_kind),
    .idx    (req_reg),
    .waddr  (req_waddr)
  );

  cpbank_lane #(.DATA_W(DATA_W)) u_lane (
    .kind   (q_kind),
    .sel_hi (q_hi),
    .bit_idx(q_bit),
    .rdata  (ram_rdata),
    .wdata  (q_wdata),
    .rd_out (lane_rd),
    .merged (lane_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ram_en    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      q_kind    <= ACC_WORD;
      q_write   <= 1'b0;
      q_hi      <= 1'b0;
      q_bit     <= '0;
      q_wdata   <= '0;
    end else begin
      ram_en   <= 1'b0;
      ram_we   <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ram_en   <= 1'b1;
            ram_addr <= req_waddr;
            q_kind   <= in_kind;
            q_write  <= req_write;
            q_hi     <= req_reg[0];
            q_bit    <= req_bit;
            q_wdata  <= req_wdata;
            if (req_write && in_kind != ACC_BYTE && in_kind != ACC_BIT) begin
              ram_we    <= 1'b1;
              ram_wdata <= req_wdata;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: state <= ST_DATA;
        ST_DATA: begin
          state <= ST_IDLE;
          if (q_write) begin
            ram_en    <= 1'b1;
            ram_we    <= 1'b1;
            ram_wdata <= lane_merged;
          end else begin
            rd_valid <= 1'b1;
            rd_data  <= lane_rd;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_SLOW_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !req_busy &&
      (!req_write || req_kind == 2'd1 || req_kind == 2'd2))) |-> req_busy); // R7

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R3

  AST_READ_THEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ram_en && !ram_we) |=> !ram_en); // R7

  AST_WORD_WRITE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !req_busy && req_write && req_kind == 2'd0))
      |-> (!req_busy && ram_en && ram_we)); // R10
endmodule

// File: tb/cpbank_unit_test.sv
`timescale 1ns/1ps
module cpbank_unit_test;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int WW = AW - 1;
  localparam int DEPTH = 1 << WW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [3:0] req_reg = '0, req_bit = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_busy, rd_valid;
  logic [DW-1:0] rd_data;
  logic cp_load = 1'b0, scxt_valid = 1'b0;
  logic [AW-1:0] cp_wdata = '0, scxt_cp = '0;
  logic [AW-1:0] cp_value, push_data;
  logic push_valid, ram_en, ram_we;
  logic [WW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;

  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] gold [DEPTH];
  logic [AW-1:0] cp_m = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata     <= mem[ram_addr];
    end
  end

  cpbank_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_reg(req_reg), .req_bit(req_bit),
    .req_wdata(req_wdata), .req_busy(req_busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .cp_load(cp_load), .cp_wdata(cp_wdata),
    .scxt_valid(scxt_valid), .scxt_cp(scxt_cp), .cp_value(cp_value),
    .push_valid(push_valid), .push_data(push_data), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] word_of(input logic [1:0] k, input logic [3:0] r);
    logic [3:0] w;
    w = (k == 2'd1) ? {1'b0, r[3:1]} : r;
    return WW'((cp_m >> 1) + w);
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [1:0] k, input logic [3:0] r, input logic [3:0] b);
    logic [DW-1:0] v;
    v = gold[word_of(k, r)];
    if (k == 2'd1) return r[0] ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
    if (k == 2'd2) return {15'd0, v[b]};
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_write(input logic [1:0] k, input logic [3:0] r, input logic [3:0] b, input logic [DW-1:0] d);
    logic [DW-1:0] v;
    v = gold[word_of(k, r)];
    if (k == 2'd1) begin
      if (r[0]) v[15:8] = d[7:0]; else v[7:0] = d[7:0];
    end else if (k == 2'd2) begin
      v[b] = d[0];
    end else begin
      v = d;
    end
    return v;
  endfunction

  // One access; intrude drives a competing word write during the busy window.
  task automatic access(input logic [1:0] k, input bit wr, input logic [3:0] r,
                        input logic [3:0] b, input logic [DW-1:0] d, input bit intrude);
    logic [WW-1:0] wa;
    logic [DW-1:0] ev;
    wa = word_of(k, r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_kind = k; req_reg = r; req_bit = b; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ram_en && ram_addr == wa, "R2 address", 32'(ram_addr), 32'(wa));
    if (wr && k == 2'd0) begin
      chk(!req_busy && ram_we && ram_wdata == d, "R10 word write", 32'(ram_wdata), 32'(d));
      gold[wa] = d;
    end else begin
      chk(req_busy, "R7 busy cycle 1", 32'(req_busy), 32'd1);
      if (intrude) begin
        req_valid = 1'b1; req_write = 1'b1; req_kind = 2'd0; req_reg = r ^ 4'd1; req_wdata = ~d;
      end
      @(negedge clk);
      chk(req_busy, "R7 busy cycle 2", 32'(req_busy), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_busy, "R7 busy released", 32'(req_busy), 32'd0);
      if (!wr) begin
        ev = exp_read(k, r, b);
        chk(rd_valid && rd_data == ev,
            (k == 2'd0) ? "R3 word read" : (k == 2'd1) ? "R4 byte read" : "R6 bit read",
            32'(rd_data), 32'(ev));
      end else begin
        ev = exp_write(k, r, b, d);
        chk(ram_en && ram_we && ram_wdata == ev,
            (k == 2'd1) ? "R5 byte merge" : "R6 bit merge", 32'(ram_wdata), 32'(ev));
        gold[wa] = ev;
      end
    end
  endtask

  task automatic set_cp(input logic [AW-1:0] v);
    @(negedge clk);
    cp_load = 1'b1; cp_wdata = v;
    @(negedge clk);
    cp_load = 1'b0;
    cp_m = v & ~AW'(1);
    chk(cp_value == cp_m, "R8 pointer load", 32'(cp_value), 32'(cp_m));
  endtask

  task automatic do_switch(input logic [AW-1:0] v, input bit with_load);
    logic [AW-1:0] old;
    old = cp_m;
    @(negedge clk);
    scxt_valid = 1'b1; scxt_cp = v;
    if (with_load) begin cp_load = 1'b1; cp_wdata = ~v; end
    @(negedge clk);
    scxt_valid = 1'b0; cp_load = 1'b0;
    cp_m = v & ~AW'(1);
    chk(cp_value == cp_m, "R9 switch pointer", 32'(cp_value), 32'(cp_m));
    chk(push_valid && push_data == old, "R9 push old", 32'(push_data), 32'(old));
    @(negedge clk);
    chk(!push_valid, "R9 push one cycle", 32'(push_valid), 32'd0);
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]  = DW'($urandom);
      gold[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(cp_value == '0 && !push_valid && !req_busy && !rd_valid && !ram_en,
        "R1 reset state", 32'(cp_value), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(cp_value == '0 && !push_valid && !req_busy && !rd_valid && !ram_en,
        "R1 after reset", 32'(cp_value), 32'd0);

    // Directed corner cases
    access(2'd0, 1'b0, 4'd0, 4'd0, '0, 1'b0);          // R3
    access(2'd0, 1'b1, 4'd15, 4'd0, 16'hA5C3, 1'b0);   // R10
    access(2'd0, 1'b0, 4'd15, 4'd0, '0, 1'b0);         // R3
    set_cp(12'h123);                                   // R8 odd value
    access(2'd1, 1'b1, 4'd15, 4'd0, 16'h005A, 1'b0);   // R5 high half of word 7
    access(2'd1, 1'b0, 4'd15, 4'd0, '0, 1'b0);         // R4
    access(2'd1, 1'b1, 4'd14, 4'd0, 16'hFF3C, 1'b0);   // R5 low half
    access(2'd1, 1'b0, 4'd14, 4'd0, '0, 1'b0);         // R4
    access(2'd0, 1'b0, 4'd7, 4'd0, '0, 1'b0);          // R5 both halves intact
    access(2'd2, 1'b1, 4'd3, 4'd15, 16'h0001, 1'b0);   // R6 bit 15
    access(2'd2, 1'b1, 4'd3, 4'd0, 16'hFFFE, 1'b0);    // R6 bit 0 cleared
    access(2'd2, 1'b0, 4'd3, 4'd15, '0, 1'b0);         // R6
    access(2'd0, 1'b0, 4'd3, 4'd0, '0, 1'b0);          // R6 rest intact
    access(2'd0, 1'b0, 4'd4, 4'd0, '0, 1'b1);          // R7 intrusion on reg 5
    access(2'd0, 1'b0, 4'd5, 4'd0, '0, 1'b0);          // R7 reg 5 unchanged
    set_cp(12'hFFC);                                   // R2 wrap
    access(2'd0, 1'b1, 4'd9, 4'd0, 16'h1357, 1'b0);
    access(2'd0, 1'b0, 4'd9, 4'd0, '0, 1'b0);
    do_switch(12'h241, 1'b0);                          // R9
    do_switch(12'h380, 1'b1);                          // R9 switch beats load
    access(2'd0, 1'b0, 4'd2, 4'd0, '0, 1'b0);

    // Random mix across banks
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom % 20);
      if (sel == 0)      set_cp(AW'($urandom));
      else if (sel == 1) do_switch(AW'($urandom), bit'($urandom % 2));
      else access(2'($urandom % 3), bit'($urandom % 2), 4'($urandom),
                  4'($urandom), DW'($urandom), bit'($urandom % 8 == 0));
    end

    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      if (mem[i] !== gold[i]) begin
        chk(1'b0, "R5 R6 memory image", 32'(mem[i]), 32'(gold[i]));
        break;
      end
    end
    chk(1'b1, "R2 memory image scanned", 32'd0, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule